// File: doc/BRIEF.md
# Reloadable Countdown Timer Bank

This block holds five independent 32-bit down-counters behind one register port. Each channel has a count buffer that software writes ahead of time. Channels 0 to 3 also have a compare buffer, which is stored but drives no waveform. A shared control word carries, for every channel, a start bit, a manual-load bit, an auto-reload bit and, on channels 0 to 3, an output-invert bit. The invert bit is stored only. Software can read each live counter through an observation register but cannot write it.

Control actions are triggered by edges in the control word when it is written, not by the levels of its bits. Writing a manual-load bit from 0 to 1 copies the count buffer into the counter. Writing a start bit from 0 to 1 runs the counter, and writing it from 1 to 0 stops it. A running counter drops by one on each cycle where its tick-enable input is high. A tick that arrives while the counter is at zero is an expiry. On expiry the counter either reloads and keeps running, or stops and has its start bit cleared by hardware. Each expiry gives a one-cycle pulse on that channel's expiry output. Tick generation and interrupt status belong to the surrounding logic.

Top module: `rtimer_bank`

## Requirements
- R1: After reset every buffer, every counter, the control word and all expiry outputs are zero, and all counters are stopped.
- R2: Count buffer of channel c is at byte offset 0x0C+12c. Compare buffer of channels 0..3 is at 0x10+12c. Observation register of channels 0..3 is at 0x14+12c; for channel 4 it is at 0x40. Buffers read back what was written. A write to an observation register has no effect.
- R3: The control word is at offset 0x08. Channel 0 uses bits 0..3 and channel c≥1 uses bits 4c+4 upward, in the order start, manual-load, invert, auto-reload. Channel 4 uses bit 20 for start, bit 21 for manual-load and bit 22 for auto-reload. All other bits read as zero, so writing all ones reads back 0x007FFF0F.
- R4: A control write that takes a manual-load bit from 0 to 1 loads that channel's count buffer into its counter. A write that leaves the bit at 1 loads nothing.
- R5: A start bit taken from 0 to 1 runs the counter, and one taken from 1 to 0 stops it. A stopped counter ignores ticks.
- R6: A running counter above zero decrements by one on each cycle where its tick is high.
- R7: A tick on a running counter that is at zero is an expiry. It raises that channel's expiry output for exactly one cycle, in the cycle after the tick.
- R8: On expiry with auto-reload set, the counter takes the count buffer value and stays running.
- R9: On expiry with auto-reload clear, the counter stays at zero and its start bit reads back as 0.
- R10: If a control write lands in the same cycle as an expiry, the expiry pulse still occurs and the written control value is stored as written, overriding the hardware start-bit clear.
- R11: Reads of unmapped offsets (for example 0x00, 0x04, 0x44) return zero, and writes to them change nothing.
- R12: Read data is registered: it reflects the offset presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte offset for reads and writes |
| reg_wr_en | input | 1 | Write strobe for the offset on reg_addr |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_addr |
| tick_en | input | 5 | Per-channel count enable |
| expire | output | 5 | Per-channel one-cycle expiry pulse |

## Verification
A control-word write and a counter expiry can fall in the same cycle, and both want to change the same start bit. The bench provokes this by writing channel 1's control field while also raising its tick, with the counter at zero and auto-reload clear. It then checks that the expiry pulse appears, that the control word reads back exactly as written, and that a further tick expires the channel again, which shows the channel was still running.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;

  function automatic int unsigned ctl_base(int unsigned ch);
    return (ch == 0) ? 0 : 4 * ch + 4;
  endfunction

  function automatic int unsigned ctl_start(int unsigned ch);
    return ctl_base(ch);
  endfunction

  function automatic int unsigned ctl_man(int unsigned ch);
    return ctl_base(ch) + 1;
  endfunction

  // last channel has no invert bit, so its reload bit moves down by one
  function automatic int unsigned ctl_arl(int unsigned ch, int unsigned n);
    return (ch == n - 1) ? ctl_base(ch) + 2 : ctl_base(ch) + 3;
  endfunction

  function automatic logic [31:0] ctl_mask(int unsigned n);
    logic [31:0] m;
    m = '0;
    for (int unsigned c = 0; c < n; c++) begin
      m[ctl_base(c)]     = 1'b1;
      m[ctl_base(c) + 1] = 1'b1;
      m[ctl_base(c) + 2] = 1'b1;
      if (c != n - 1) m[ctl_base(c) + 3] = 1'b1;
    end
    return m;
  endfunction

  localparam int unsigned CTL_OFF = 8;

  function automatic int unsigned cntb_off(int unsigned ch);
    return 12 + 12 * ch;
  endfunction

  function automatic int unsigned cmpb_off(int unsigned ch);
    return 16 + 12 * ch;
  endfunction

  // last channel has no compare buffer; its observation slot takes that place
  function automatic int unsigned obs_off(int unsigned ch, int unsigned n);
    return (ch == n - 1) ? 16 + 12 * ch : 20 + 12 * ch;
  endfunction

endpackage

// File: rtl/rtimer_ctrl.sv
module rtimer_ctrl
  import rtimer_pkg::*;
#(
  parameter int unsigned N_CH   = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_CH-1:0]   hw_clr,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [N_CH-1:0]   run,
  output logic [N_CH-1:0]   arl,
  output logic [N_CH-1:0]   load
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(ctl_mask(N_CH));

  logic [DATA_W-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    for (int unsigned i = 0; i < N_CH; i++) clr_vec[ctl_start(i)] = hw_clr[i];
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_fld
    assign run[g]  = ctrl_q[ctl_start(g)];
    assign arl[g]  = ctrl_q[ctl_arl(g, N_CH)];
    assign load[g] = wr_en & wdata[ctl_man(g)] & ~ctrl_q[ctl_man(g)];
  end

  // a software write overrides the hardware start clear of the same cycle
  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata & MASK;
    else            ctrl_q <= ctrl_q & ~clr_vec;
  end
endmodule

// File: rtl/rtimer_chan.sv
module rtimer_chan #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             arl,
  input  logic             load,
  input  logic [CNT_W-1:0] buf_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire,
  output logic             hw_clr
);
  logic at_zero, exp_now;

  assign at_zero = (cnt_q == '0);
  assign exp_now = run & tick & at_zero;
  assign hw_clr  = exp_now & ~arl;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      expire <= 1'b0;
    end else begin
      expire <= exp_now;
      if (load)                cnt_q <= buf_val;
      else if (exp_now && arl) cnt_q <= buf_val;
      else if (run && tick && !at_zero) cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/rtimer_regs.sv
module rtimer_regs
  import rtimer_pkg::*;
#(
  parameter int unsigned N_CH   = 5,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [DATA_W-1:0]           ctrl_q,
  input  logic [N_CH-1:0][CNT_W-1:0]  cnt,
  output logic [N_CH-1:0][CNT_W-1:0]  cntb,
  output logic [DATA_W-1:0]           rdata
);
  logic [N_CH-1:0][CNT_W-1:0] cmpb;
  logic [DATA_W-1:0] rd_nx;

  for (genvar g = 0; g < N_CH; g++) begin : g_buf
    logic [CNT_W-1:0] cnt_r;
    always_ff @(posedge clk) begin
      if (rst) cnt_r <= '0;
      else if (wr_en && addr == ADDR_W'(cntb_off(g))) cnt_r <= CNT_W'(wdata);
    end
    assign cntb[g] = cnt_r;

    if (g < N_CH - 1) begin : g_cmp
      logic [CNT_W-1:0] cmp_r;
      always_ff @(posedge clk) begin
        if (rst) cmp_r <= '0;
        else if (wr_en && addr == ADDR_W'(cmpb_off(g))) cmp_r <= CNT_W'(wdata);
      end
      assign cmpb[g] = cmp_r;
    end else begin : g_nocmp
      assign cmpb[g] = '0;
    end
  end

  always_comb begin
    rd_nx = '0;
    if (addr == ADDR_W'(CTL_OFF)) rd_nx = ctrl_q;
    for (int unsigned i = 0; i < N_CH; i++) begin
      if (addr == ADDR_W'(cntb_off(i))) rd_nx = DATA_W'(cntb[i]);
      if (i < N_CH - 1 && addr == ADDR_W'(cmpb_off(i))) rd_nx = DATA_W'(cmpb[i]);
      if (addr == ADDR_W'(obs_off(i, N_CH))) rd_nx = DATA_W'(cnt[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nx;
  end
endmodule

// File: rtl/rtimer_bank.sv
module rtimer_bank
  import rtimer_pkg::*;
#(
  parameter int unsigned N_CH   = 5,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_CH-1:0]   tick_en,
  output logic [N_CH-1:0]   expire
);
  logic                       ctrl_wr;
  logic [DATA_W-1:0]          ctrl_q;
  logic [N_CH-1:0]            run_v, arl_v, load_v, clr_v;
  logic [N_CH-1:0][CNT_W-1:0] cnt_v, cntb_v;

  assign ctrl_wr = reg_wr_en && (reg_addr == ADDR_W'(CTL_OFF));

  rtimer_ctrl #(.N_CH(N_CH), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst(rst), .wr_en(ctrl_wr), .wdata(reg_wdata),
    .hw_clr(clr_v), .ctrl_q(ctrl_q), .run(run_v), .arl(arl_v), .load(load_v)
  );

  rtimer_regs #(.N_CH(N_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .cnt(cnt_v), .cntb(cntb_v), .rdata(reg_rdata)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    rtimer_chan #(.CNT_W(CNT_W)) chan_i (
      .clk(clk), .rst(rst), .tick(tick_en[g]), .run(run_v[g]), .arl(arl_v[g]),
      .load(load_v[g]), .buf_val(cntb_v[g]), .cnt_q(cnt_v[g]),
      .expire(expire[g]), .hw_clr(clr_v[g])
    );
  end
endmodule

// File: rtl/rtimer_bank_chk.sv
module rtimer_bank_chk #(
  parameter int unsigned N_CH   = 5,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       ctrl_wr,
  input logic [N_CH-1:0]            tick_en,
  input logic [N_CH-1:0]            expire,
  input logic [N_CH-1:0]            run_v,
  input logic [N_CH-1:0]            arl_v,
  input logic [N_CH-1:0]            load_v,
  input logic [N_CH-1:0][CNT_W-1:0] cnt_v,
  input logic [N_CH-1:0][CNT_W-1:0] cntb_v,
  input logic [DATA_W-1:0]          ctrl_q
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl_q == '0 && cnt_v == '0 && expire == '0));

  for (genvar g = 0; g < N_CH; g++) begin : g_a
    assert_manual_load_R4: assert property (@(posedge clk) disable iff (rst)
      load_v[g] |=> cnt_v[g] == $past(cntb_v[g]));

    assert_stopped_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (!run_v[g] && !load_v[g]) |=> $stable(cnt_v[g]));

    assert_decrement_R6: assert property (@(posedge clk) disable iff (rst)
      (run_v[g] && tick_en[g] && cnt_v[g] != '0 && !load_v[g])
      |=> cnt_v[g] == $past(cnt_v[g]) - CNT_W'(1));

    assert_expire_cause_R7: assert property (@(posedge clk) disable iff (rst)
      expire[g] |-> $past(run_v[g] && tick_en[g] && cnt_v[g] == '0));

    assert_auto_reload_R8: assert property (@(posedge clk) disable iff (rst)
      (run_v[g] && tick_en[g] && cnt_v[g] == '0 && arl_v[g] && !load_v[g] && !ctrl_wr)
      |=> (cnt_v[g] == $past(cntb_v[g]) && run_v[g]));

    assert_oneshot_stop_R9: assert property (@(posedge clk) disable iff (rst)
      (run_v[g] && tick_en[g] && cnt_v[g] == '0 && !arl_v[g] && !ctrl_wr)
      |=> !run_v[g]);
  end
endmodule

bind rtimer_bank rtimer_bank_chk #(.N_CH(N_CH), .CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .tick_en(tick_en), .expire(expire),
  .run_v(run_v), .arl_v(arl_v), .load_v(load_v), .cnt_v(cnt_v),
  .cntb_v(cntb_v), .ctrl_q(ctrl_q)
);

// File: tb/rtimer_bank_tb_top.sv
`timescale 1ns/1ps
module rtimer_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4:0]  tick_en = '0;
  logic [4:0]  expire;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_vld = 1'b0;
  logic        mon_due = 1'b0;

  always #2 clk = ~clk;

  rtimer_bank dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en), .expire(expire)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // scoreboard monitor: read data lands one cycle after the offset (R12)
  always @(posedge clk) mon_due <= rd_vld;
  always @(negedge clk) begin
    if (mon_due && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(reg_rdata === e, t, reg_rdata, e);
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_vld = 1'b1;
    @(negedge clk);
    rd_vld = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic tick(input logic [4:0] m, input logic [4:0] e, input string t);
    @(negedge clk);
    tick_en = m;
    @(negedge clk);
    tick_en = '0;
    check(expire === e, t, 32'(expire), 32'(e));
  endtask

  task automatic wr_tick(input logic [31:0] d, input logic [4:0] m, input logic [4:0] e, input string t);
    @(negedge clk);
    reg_addr = 8'h08; reg_wdata = d; reg_wr_en = 1'b1; tick_en = m;
    @(negedge clk);
    reg_wr_en = 1'b0; tick_en = '0;
    check(expire === e, t, 32'(expire), 32'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check(expire === 5'b0, "R1 expire", 32'(expire), 32'd0);
    rd(8'h08, 32'h0, "R1 control");
    rd(8'h0C, 32'h0, "R1 buffer0");
    rd(8'h40, 32'h0, "R1 count4");

    // R2 buffers and read-only observation
    wr(8'h0C, 32'd3);
    rd(8'h0C, 32'd3, "R2 buffer0");
    wr(8'h1C, 32'hAA);
    rd(8'h1C, 32'hAA, "R2 compare1");
    wr(8'h3C, 32'd2);
    rd(8'h3C, 32'd2, "R2 buffer4");
    wr(8'h14, 32'h55);
    rd(8'h14, 32'h0, "R2 obs0 not writable");

    // R11 unmapped
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0, "R11 offset 0x00");
    rd(8'h44, 32'h0, "R11 offset 0x44");

    // R4 manual load on channel 0 (bit 1), R5 stopped ignores ticks
    wr(8'h08, 32'h2);
    rd(8'h14, 32'd3, "R4 manual load ch0");
    tick(5'b00001, 5'b0, "R5 stopped no expire");
    rd(8'h14, 32'd3, "R5 stopped holds");

    // R5 start (bit 0), R6 decrement
    wr(8'h08, 32'h3);
    tick(5'b00001, 5'b0, "R6 tick 3->2");
    rd(8'h14, 32'd2, "R6 count ch0");
    wr(8'h0C, 32'd9);
    wr(8'h08, 32'h3);
    rd(8'h14, 32'd2, "R4 no load when bit stays 1");
    tick(5'b00001, 5'b0, "R6 tick 2->1");
    tick(5'b00001, 5'b0, "R6 tick 1->0");
    tick(5'b00001, 5'b00001, "R7 expiry ch0");
    @(negedge clk);
    check(expire === 5'b0, "R7 single cycle pulse", 32'(expire), 32'd0);
    rd(8'h08, 32'h2, "R9 start cleared ch0");
    rd(8'h14, 32'd0, "R9 count stays zero");
    tick(5'b00001, 5'b0, "R9 stopped after expiry");

    // R8 auto-reload on channel 2 (start 12, load 13, reload 15)
    wr(8'h24, 32'd1);
    wr(8'h08, 32'h0000_A000);
    wr(8'h08, 32'h0000_B000);
    tick(5'b00100, 5'b0, "R6 ch2 1->0");
    tick(5'b00100, 5'b00100, "R8 expiry ch2");
    rd(8'h08, 32'h0000_B000, "R8 still running");
    rd(8'h2C, 32'd1, "R8 reloaded ch2");
    tick(5'b00100, 5'b0, "R6 ch2 reload 1->0");
    wr(8'h08, 32'h0000_A000);
    tick(5'b00100, 5'b0, "R5 stop ch2 no expire");
    rd(8'h2C, 32'd0, "R5 stop ch2 holds");

    // channel 4 (start 20, load 21, reload 22), R3 layout
    wr(8'h08, 32'h0020_0000);
    rd(8'h40, 32'd2, "R3 ch4 load at bit 21");
    wr(8'h08, 32'h0030_0000);
    tick(5'b10000, 5'b0, "R3 ch4 start at bit 20");
    rd(8'h40, 32'd1, "R6 ch4 count");
    tick(5'b10000, 5'b0, "R6 ch4 1->0");
    tick(5'b10000, 5'b10000, "R7 expiry ch4");
    rd(8'h08, 32'h0020_0000, "R9 ch4 start cleared");

    // R10 control write collides with expiry on channel 1 (start 8, load 9, invert 10)
    wr(8'h08, 32'h0000_0200);
    wr(8'h08, 32'h0000_0300);
    wr_tick(32'h0000_0700, 5'b00010, 5'b00010, "R10 expiry during write");
    rd(8'h08, 32'h0000_0700, "R10 written value kept");
    tick(5'b00010, 5'b00010, "R10 channel still running");
    rd(8'h08, 32'h0000_0600, "R9 ch1 start cleared");

    // R3 mask of defined control bits
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h007F_FF0F, "R3 control mask");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule